// File: doc/BRIEF.md
# Dual-Port Token Semaphore Bank

This block holds a small set of binary hardware semaphores that two independent ports, called left and right, share. The bank sits in its own address space, apart from any data memory. Each port has a bank enable, a write strobe, an output enable, an address and a data bus. A port asks for a token by writing 0 on data bit 0 and gives it back by writing 1. It then reads to see whether it now holds the token. Flags are active low. The owning side reads all zeros, and every other view reads all ones.

Each semaphore keeps one request latch per side and a small ownership state. A request from the side that is locked out is not lost. It waits in that side's latch, and the token passes to it in the same cycle that the owner releases. The bank never stalls either port. A read value is captured at the start of a read and held until the read ends, so a write from the other side cannot change the data in the middle of a read.

Top module: `dual_token_bank`

## Requirements
- R1: After reset every semaphore is free: a read of any index from either side returns 16'hFFFF, and an idle port's read data is 16'h0000.
- R2: The semaphore index is address bits 2..0. Higher address bits and data bits 15..1 have no effect on which semaphore is written or on the value written.
- R3: Writing 0 to a free semaphore gives the token to the writer. The writer then reads 16'h0000 and the other side reads 16'hFFFF.
- R4: While one side owns a semaphore, a 0 written by the other side changes neither side's read value.
- R5: A 0 written by the locked-out side stays pending. When the owner writes 1, the pending side becomes the owner in that same cycle.
- R6: When the owner writes 1 and the other side has no pending request, the semaphore becomes free and both sides read 16'hFFFF.
- R7: If both sides write 0 to the same free semaphore in one cycle, left gets the token and right's request stays pending.
- R8: A read is active while bank enable and output enable are high and the write strobe is low. Its data appears one cycle after the read starts, with the reading side's flag copied onto all 16 bits.
- R9: The read data is captured in the first cycle of an active read and held for as long as the read stays active, even if the other side's writes change the flag.
- R10: One cycle after a port stops reading, its read data returns to 16'h0000.
- R11: Each semaphore changes only through writes to its own index.
- R12: On one semaphore, the following sequence gives these left/right reads: left 0 (0/1), right 0 (0/1), left 1 (1/0), left 0 (1/0), right 1 (0/1), left 1 (1/1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lSel | input | 1 | Left bank enable |
| lWe | input | 1 | Left write strobe |
| lOe | input | 1 | Left output enable |
| lAddr | input | 13 | Left address; bits 2..0 pick the semaphore |
| lWdata | input | 16 | Left write data; bit 0 is used |
| lRdata | output | 16 | Left read data |
| rSel | input | 1 | Right bank enable |
| rWe | input | 1 | Right write strobe |
| rOe | input | 1 | Right output enable |
| rAddr | input | 13 | Right address; bits 2..0 pick the semaphore |
| rWdata | input | 16 | Right write data; bit 0 is used |
| rRdata | output | 16 | Right read data |

## Verification
Two kinds of events can land in one cycle. The first is that both sides write the same semaphore: requests on a free flag, or a release from the owner together with a request from the other side. The bench drives these pairs on purpose and also gets them from random traffic aimed at a few indices. The second is a held read on one side while the other side writes the flag being read. The bench checks that the read data stays frozen, and then that a new read shows the new owner. Expected values come from a small ownership model inside the bench.

// File: rtl/token_bank_pkg.sv
package token_bank_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // strobes from one side's control to the shared datapath
  typedef struct packed {
    logic wrEn;     // write this cycle
    logic wrBit;    // value written (0 = request, 1 = release)
    logic active;   // read in progress
    logic capture;  // first cycle of a read
  } side_strobe_t;

endpackage

// File: rtl/token_side_ctrl.sv
module token_side_ctrl
  import token_bank_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output side_strobe_t      stb,
  output logic [IDX_W-1:0]  idx
);

  logic readNow;
  logic readPrev;
  logic unusedUpper;

  assign unusedUpper = ^{wdata[DATA_W-1:1], addr[ADDR_W-1:IDX_W]};
  assign readNow = sel && oe && !we;
  assign idx = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) readPrev <= 1'b0;
    else       readPrev <= readNow;
  end

  always_comb begin
    stb.wrEn    = sel && we;
    stb.wrBit   = wdata[0];
    stb.active  = readNow;
    stb.capture = readNow && !readPrev;
  end

endmodule

// File: rtl/token_cell.sv
module token_cell
  import token_bank_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic lWr,
  input  logic lBit,
  input  logic rWr,
  input  logic rBit,
  output logic lView,
  output logic rView
);

  logic   reqL, reqR, nReqL, nReqR;
  owner_e owner, nOwner;

  always_comb begin
    nReqL  = lWr ? lBit : reqL;
    nReqR  = rWr ? rBit : reqR;
    nOwner = owner;
    unique case (owner)
      OWN_LEFT:  if (nReqL) nOwner = nReqR ? OWN_NONE : OWN_RIGHT;
      OWN_RIGHT: if (nReqR) nOwner = nReqL ? OWN_NONE : OWN_LEFT;
      default: begin
        if (!nReqL)      nOwner = OWN_LEFT;   // left wins a tie
        else if (!nReqR) nOwner = OWN_RIGHT;
        else             nOwner = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqL  <= 1'b1;
      reqR  <= 1'b1;
      owner <= OWN_NONE;
    end else begin
      reqL  <= nReqL;
      reqR  <= nReqR;
      owner <= nOwner;
    end
  end

  assign lView = (owner != OWN_LEFT);
  assign rView = (owner != OWN_RIGHT);

endmodule

// File: rtl/token_datapath.sv
module token_datapath
  import token_bank_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  side_strobe_t       stbL,
  input  logic [IDX_W-1:0]   idxL,
  input  side_strobe_t       stbR,
  input  logic [IDX_W-1:0]   idxR,
  output logic [DATA_W-1:0]  lRdata,
  output logic [DATA_W-1:0]  rRdata,
  output logic [NUM_SEM-1:0] lViewVec,
  output logic [NUM_SEM-1:0] rViewVec
);

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
    token_cell u_cell (
      .clk   (clk),
      .rstN  (rstN),
      .lWr   (stbL.wrEn && (idxL == IDX_W'(i))),
      .lBit  (stbL.wrBit),
      .rWr   (stbR.wrEn && (idxR == IDX_W'(i))),
      .rBit  (stbR.wrBit),
      .lView (lViewVec[i]),
      .rView (rViewVec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN || !stbL.active) lRdata <= '0;
    else if (stbL.capture)     lRdata <= {DATA_W{lViewVec[idxL]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN || !stbR.active) rRdata <= '0;
    else if (stbR.capture)     rRdata <= {DATA_W{rViewVec[idxR]}};
  end

endmodule

// File: rtl/dual_token_bank.sv
module dual_token_bank
  import token_bank_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lSel,
  input  logic              lWe,
  input  logic              lOe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  input  logic              rSel,
  input  logic              rWe,
  input  logic              rOe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata
);

  side_strobe_t       stbL, stbR;
  logic [IDX_W-1:0]   idxL, idxR;
  logic [NUM_SEM-1:0] lViewVec, rViewVec;

  token_side_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrlL (
    .clk(clk), .rstN(rstN), .sel(lSel), .we(lWe), .oe(lOe),
    .addr(lAddr), .wdata(lWdata), .stb(stbL), .idx(idxL)
  );

  token_side_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrlR (
    .clk(clk), .rstN(rstN), .sel(rSel), .we(rWe), .oe(rOe),
    .addr(rAddr), .wdata(rWdata), .stb(stbR), .idx(idxR)
  );

  token_datapath #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .stbL(stbL), .idxL(idxL), .stbR(stbR), .idxR(idxR),
    .lRdata(lRdata), .rRdata(rRdata),
    .lViewVec(lViewVec), .rViewVec(rViewVec)
  );

endmodule

// File: rtl/dual_token_bank_checker.sv
module dual_token_bank_checker #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               lSel,
  input logic               lWe,
  input logic               lOe,
  input logic [ADDR_W-1:0]  lAddr,
  input logic [DATA_W-1:0]  lWdata,
  input logic [DATA_W-1:0]  lRdata,
  input logic               rSel,
  input logic               rWe,
  input logic               rOe,
  input logic [ADDR_W-1:0]  rAddr,
  input logic [DATA_W-1:0]  rWdata,
  input logic [DATA_W-1:0]  rRdata,
  input logic [NUM_SEM-1:0] lViewVec,
  input logic [NUM_SEM-1:0] rViewVec
);

  logic lAct, rAct;
  assign lAct = lSel && lOe && !lWe;
  assign rAct = rSel && rOe && !rWe;

  // R3/R7: a token never has two holders
  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    (lViewVec | rViewVec) == {NUM_SEM{1'b1}});

  // R8: read data is a replicated flag or idle zero
  a_r8_left_replicated: assert property (@(posedge clk) disable iff (!rstN)
    (lRdata == '0) || (lRdata == '1));
  a_r8_right_replicated: assert property (@(posedge clk) disable iff (!rstN)
    (rRdata == '0) || (rRdata == '1));

  // R9: held while the read stays active
  a_r9_left_hold: assert property (@(posedge clk) disable iff (!rstN)
    lAct && $past(lAct) |=> $stable(lRdata));
  a_r9_right_hold: assert property (@(posedge clk) disable iff (!rstN)
    rAct && $past(rAct) |=> $stable(rRdata));

  // R10: idle port returns zero
  a_r10_left_idle: assert property (@(posedge clk) disable iff (!rstN)
    !lAct |=> lRdata == '0);
  a_r10_right_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rAct |=> rRdata == '0);

  // R4: only the owner's own release can take a token away
  for (genvar i = 0; i < NUM_SEM; i++) begin : g_keep
    a_r4_left_keeps: assert property (@(posedge clk) disable iff (!rstN)
      !lViewVec[i] && !(lSel && lWe && lWdata[0] && lAddr[IDX_W-1:0] == IDX_W'(i))
      |=> !lViewVec[i]);
    a_r4_right_keeps: assert property (@(posedge clk) disable iff (!rstN)
      !rViewVec[i] && !(rSel && rWe && rWdata[0] && rAddr[IDX_W-1:0] == IDX_W'(i))
      |=> !rViewVec[i]);
  end

endmodule

bind dual_token_bank dual_token_bank_checker #(
  .NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN),
  .lSel(lSel), .lWe(lWe), .lOe(lOe), .lAddr(lAddr), .lWdata(lWdata), .lRdata(lRdata),
  .rSel(rSel), .rWe(rWe), .rOe(rOe), .rAddr(rAddr), .rWdata(rWdata), .rRdata(rRdata),
  .lViewVec(lViewVec), .rViewVec(rViewVec)
);

// File: tb/dual_token_bank_test.sv
module dual_token_bank_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lSel, lWe, lOe, rSel, rWe, rOe;
  logic [12:0] lAddr, rAddr;
  logic [15:0] lWdata, rWdata;
  logic [15:0] lRdata, rRdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int own  [8];   // 0 none, 1 left, 2 right
  bit reqL [8];
  bit reqR [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_token_bank uut (
    .clk(clk), .rstN(rstN),
    .lSel(lSel), .lWe(lWe), .lOe(lOe), .lAddr(lAddr), .lWdata(lWdata), .lRdata(lRdata),
    .rSel(rSel), .rWe(rWe), .rOe(rOe), .rAddr(rAddr), .rWdata(rWdata), .rRdata(rRdata)
  );

  function automatic bit viewOf(input int side, input int i);
    return side == 0 ? (own[i] != 1) : (own[i] != 2);
  endfunction

  function automatic void applyModel(input bit lw, input int li, input bit lb,
                                     input bit rw, input int ri, input bit rb);
    for (int i = 0; i < 8; i++) begin
      bit nl = (lw && li == i) ? lb : reqL[i];
      bit nr = (rw && ri == i) ? rb : reqR[i];
      if (own[i] == 1)      begin if (nl) own[i] = nr ? 0 : 2; end
      else if (own[i] == 2) begin if (nr) own[i] = nl ? 0 : 1; end
      else if (!nl)         own[i] = 1;
      else if (!nr)         own[i] = 2;
      reqL[i] = nl;
      reqR[i] = nr;
    end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearAll();
    lSel = 0; lWe = 0; lOe = 0; lAddr = '0; lWdata = '0;
    rSel = 0; rWe = 0; rOe = 0; rAddr = '0; rWdata = '0;
  endtask

  // one write cycle on either or both sides
  task automatic wr2(input bit lw, input logic [12:0] la, input logic [15:0] ld,
                     input bit rw, input logic [12:0] ra, input logic [15:0] rd);
    @(negedge clk);
    lSel = lw; lWe = lw; lAddr = la; lWdata = ld;
    rSel = rw; rWe = rw; rAddr = ra; rWdata = rd;
    @(negedge clk);
    clearAll();
    applyModel(lw, int'(la[2:0]), ld[0], rw, int'(ra[2:0]), rd[0]);
  endtask

  // read one side, compare to expected flag, then check idle zero
  task automatic rd(input int side, input logic [12:0] a, input bit expBit, input string tag);
    logic [15:0] got;
    @(negedge clk);
    if (side == 0) begin lSel = 1; lOe = 1; lAddr = a; end
    else           begin rSel = 1; rOe = 1; rAddr = a; end
    @(negedge clk);
    got = (side == 0) ? lRdata : rRdata;
    check(got == {16{expBit}}, tag, got, {16{expBit}});
    clearAll();
    @(negedge clk);
    got = (side == 0) ? lRdata : rRdata;
    check(got == 16'h0000, "R10 idle after read", got, 16'h0000);
  endtask

  task automatic rdBoth(input int s, input bit le, input bit re, input string tag);
    rd(0, 13'(s), le, tag);
    rd(1, 13'(s), re, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin own[i] = 0; reqL[i] = 1; reqR[i] = 1; end
    clearAll();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check(lRdata == 16'h0 && rRdata == 16'h0, "R1 idle data", lRdata | rRdata, 16'h0);
    for (int i = 0; i < 8; i++) rdBoth(i, 1, 1, "R1 free after reset");

    // R12 reference sequence on semaphore 5, R3 R4 R5 R6 inside it
    wr2(1, 13'd5, 16'h0000, 0, 0, 0); rdBoth(5, 0, 1, "R12/R3 left takes");
    wr2(0, 0, 0, 1, 13'd5, 16'h0000); rdBoth(5, 0, 1, "R12/R4 right locked out");
    wr2(1, 13'd5, 16'h0001, 0, 0, 0); rdBoth(5, 1, 0, "R12/R5 right obtains on release");
    wr2(1, 13'd5, 16'h0000, 0, 0, 0); rdBoth(5, 1, 0, "R12/R4 left locked out");
    wr2(0, 0, 0, 1, 13'd5, 16'h0001); rdBoth(5, 0, 1, "R12/R5 left obtains");
    wr2(1, 13'd5, 16'h0001, 0, 0, 0); rdBoth(5, 1, 1, "R12/R6 free");

    // R2 higher address bits and data bits ignored
    wr2(1, 13'h1FF2, 16'hFFFE, 0, 0, 0);
    rdBoth(2, 0, 1, "R2 index from low bits, bit0 only");
    rd(1, 13'h0A02, 1, "R2 right alias reads same flag");
    rdBoth(3, 1, 1, "R11 neighbour untouched");
    wr2(1, 13'h0002, 16'h0001, 0, 0, 0);
    rdBoth(2, 1, 1, "R6 released");

    // R7 simultaneous request, left wins, right pending
    wr2(1, 13'd4, 16'h0, 1, 13'd4, 16'h0);
    rdBoth(4, 0, 1, "R7 left wins tie");
    wr2(1, 13'd4, 16'h1, 0, 0, 0);
    rdBoth(4, 1, 0, "R7/R5 right pending takes over");
    // release and request by owner/other in one cycle
    wr2(1, 13'd4, 16'h0, 1, 13'd4, 16'h1);
    rdBoth(4, 0, 1, "R5 same-cycle handover to left");
    wr2(1, 13'd4, 16'h1, 0, 0, 0);
    rdBoth(4, 1, 1, "R6 free again");

    // R9 held read while other side hands over the token
    wr2(0, 0, 0, 1, 13'd6, 16'h0);
    wr2(1, 13'd6, 16'h0, 0, 0, 0);
    @(negedge clk);
    lSel = 1; lOe = 1; lAddr = 13'd6;
    @(negedge clk);
    check(lRdata == 16'hFFFF, "R8 left sees other owner", lRdata, 16'hFFFF);
    rSel = 1; rWe = 1; rAddr = 13'd6; rWdata = 16'h1;
    @(negedge clk);
    rSel = 0; rWe = 0;
    applyModel(0, 0, 0, 1, 6, 1);
    check(lRdata == 16'hFFFF, "R9 held during other write", lRdata, 16'hFFFF);
    @(negedge clk);
    check(lRdata == 16'hFFFF, "R9 still held", lRdata, 16'hFFFF);
    clearAll();
    rd(0, 13'd6, 0, "R9 new read shows ownership");
    wr2(1, 13'd6, 16'h1, 0, 0, 0);

    // random traffic on a few indices, checked against the model
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 3);
      if (op < 3) begin
        bit lw = $urandom_range(0, 1);
        bit rw = $urandom_range(0, 1);
        logic [12:0] la = {10'($urandom), 3'($urandom_range(0, 3))};
        logic [12:0] ra = {10'($urandom), 3'($urandom_range(0, 3))};
        wr2(lw, la, 16'($urandom), rw, ra, 16'($urandom));
      end else begin
        int side = $urandom_range(0, 1);
        int s = $urandom_range(0, 7);
        rd(side, {10'($urandom), 3'(s)}, viewOf(side, s), "R3/R4/R5/R6/R7 random model read");
      end
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule